// File: doc/BRIEF.md
# PCI Target Transaction Sequencer

This block is the target side of a 32-bit PCI bus interface. It samples the bus control lines on every bus clock and decides whether a new transaction is addressed to it. It accepts memory reads and writes that fall inside a fixed address window, and configuration reads and writes selected by the IDSEL line. For a transaction it accepts, it answers with DEVSEL# and TRDY# and moves data to or from a small bank of local registers. Both single transfers and bursts are supported, and a burst runs until the initiator ends it.

The sequencer starts a transaction only when FRAME# falls, meaning FRAME# was high on the previous clock and is low on the current one. A FRAME# that is simply low, for example during another device's transaction, never starts one. The response lines and the read data bus come out as values with separate output-enable controls, ready for pad logic. The register bank is indexed by dword. During a burst the index advances one word, which is 4 bytes, for each completed data phase.

Top module: `pci_tgt_seq`

## Requirements
- R1: While reset is high, and on the first cycle after it, devsel_n and trdy_n are 1 and rsp_oe and ad_oe are 0.
- R2: An address phase is taken only on a clock where frame_n is 0 and was 1 on the previous clock. A frame_n that is low at the end of reset, or that stays low, never causes a claim.
- R3: The block claims commands 6 (memory read) and 7 (memory write) when ad_in[31:11] equals the window base and ad_in[1:0] is 00. It claims commands 10 (configuration read) and 11 (configuration write) when idsel is 1 and ad_in[1:0] is 00. The command is the value on cbe_n. Any other address phase leaves devsel_n high for the whole transaction.
- R4: On a claimed write, devsel_n and trdy_n go low in the cycle after the address phase. Each clock edge that sees irdy_n and trdy_n both low stores the bytes of ad_in whose cbe_n bit is 0 (bit i selects byte i) into the addressed register.
- R5: On a claimed read, the cycle after the address phase is a turnaround cycle: devsel_n is 0, trdy_n is 1 and ad_oe is 0. From the next cycle, trdy_n is 0, ad_oe is 1, and ad_out carries the addressed register.
- R6: The starting register index is ad_in[4:2]. It advances by one (4 bytes) after each completed data phase and wraps modulo the register count. A cycle with irdy_n high leaves the index and the data unchanged.
- R7: After a completed data phase with frame_n high, devsel_n and trdy_n are 1 and ad_oe is 0 in the next cycle, while rsp_oe is still 1. One cycle later rsp_oe is 0 unless a new claim has started.
- R8: After an address phase that is not claimed, no response is given and no new address phase is taken until frame_n and irdy_n are both high, whatever appears on ad_in, cbe_n and idsel in the meantime.
- R9: A new address phase may arrive in the cycle right after the final data phase, and it is decoded and claimed normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_n | input | 1 | FRAME#, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| idsel | input | 1 | Configuration select |
| ad_in | input | 32 | Address/data bus as seen from the bus |
| cbe_n | input | 4 | Command in the address phase, byte enables (active low) in data phases |
| ad_out | output | 32 | Read data driven toward the bus |
| ad_oe | output | 1 | Output enable for ad_out |
| devsel_n | output | 1 | DEVSEL#, active low |
| trdy_n | output | 1 | Target ready, active low |
| rsp_oe | output | 1 | Output enable for devsel_n and trdy_n |

## Verification
The hardest case to reach is a bus that looks like a valid address phase with no falling FRAME# edge. This happens when FRAME# is already low as reset is released, or when another device's transaction puts a matching configuration command on ad_in and cbe_n while idsel is high. The stimulus builds both cases on purpose. It holds FRAME# low through the reset release, and it injects a matching address pattern during the data phases of a transaction that is not claimed, which then ends by master abort. The other hard case is a back-to-back transaction in the release cycle. The stimulus reaches it by starting a configuration read with no idle cycle right after a write burst ends.

// File: rtl/tgtseq_pkg.sv
package tgtseq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TURN,
        ST_XFER,
        ST_BUSY,
        ST_DONE
    } seq_state_e;

    localparam logic [3:0] CMD_MEM_RD = 4'h6;
    localparam logic [3:0] CMD_MEM_WR = 4'h7;
    localparam logic [3:0] CMD_CFG_RD = 4'hA;
    localparam logic [3:0] CMD_CFG_WR = 4'hB;

    typedef struct packed {
        logic hit;
        logic rd;
    } claim_t;

    function automatic logic cmd_is_mem(input logic [3:0] cmd);
        return (cmd == CMD_MEM_RD) || (cmd == CMD_MEM_WR);
    endfunction

    function automatic logic cmd_is_cfg(input logic [3:0] cmd);
        return (cmd == CMD_CFG_RD) || (cmd == CMD_CFG_WR);
    endfunction

    function automatic logic cmd_is_read(input logic [3:0] cmd);
        return (cmd == CMD_MEM_RD) || (cmd == CMD_CFG_RD);
    endfunction

endpackage

// File: rtl/tgtseq_decode.sv
module tgtseq_decode
    import tgtseq_pkg::*;
#(
    parameter int          DATA_W    = 32,
    parameter int          WIN_LSB   = 11,
    parameter logic [31:0] BASE_ADDR = 32'h8000_0000,
    parameter int          IDX_W     = 3
) (
    input  logic [DATA_W-1:0] ad,
    input  logic [3:0]        cmd,
    input  logic              sel,
    output claim_t            dec,
    output logic [IDX_W-1:0]  idx
);

    logic aligned;
    logic win_hit;

    assign aligned = (ad[1:0] == 2'b00);
    assign win_hit = (ad[DATA_W-1:WIN_LSB] == BASE_ADDR[DATA_W-1:WIN_LSB]);

    always_comb begin
        dec.hit = aligned && ((win_hit && cmd_is_mem(cmd)) || (sel && cmd_is_cfg(cmd)));
        dec.rd  = cmd_is_read(cmd);
    end

    assign idx = ad[IDX_W+1:2];

endmodule

// File: rtl/tgtseq_regfile.sv
module tgtseq_regfile #(
    parameter int DATA_W = 32,
    parameter int NREGS  = 8,
    localparam int IDX_W  = $clog2(NREGS),
    localparam int NBYTES = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [NBYTES-1:0] be_n,
    output logic [DATA_W-1:0] rd_data
);

    logic [NREGS-1:0][DATA_W-1:0] bank_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            bank_q <= '0;
        end else if (wr_en) begin
            for (int b = 0; b < NBYTES; b++) begin
                if (!be_n[b]) begin
                    bank_q[idx][b*8 +: 8] <= wr_data[b*8 +: 8];
                end
            end
        end
    end

    assign rd_data = bank_q[idx];

endmodule

// File: rtl/tgtseq_fsm.sv
module tgtseq_fsm
    import tgtseq_pkg::*;
#(
    parameter int NREGS = 8,
    localparam int IDX_W = $clog2(NREGS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_n,
    input  logic             irdy_n,
    input  claim_t           dec,
    input  logic [IDX_W-1:0] dec_idx,
    output logic [IDX_W-1:0] cur_idx,
    output logic             wr_en,
    output logic             devsel_n,
    output logic             trdy_n,
    output logic             rsp_oe,
    output logic             ad_oe
);

    seq_state_e       state_q, state_d;
    logic             frame_q;
    logic             rd_q;
    logic [IDX_W-1:0] idx_q;
    logic             accept;
    logic             addr_ph;
    logic             beat;

    assign accept  = (state_q == ST_IDLE) || (state_q == ST_DONE);
    assign addr_ph = frame_q && !frame_n;
    assign beat    = (state_q == ST_XFER) && !irdy_n;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_DONE: begin
                if (addr_ph) begin
                    if (dec.hit) state_d = dec.rd ? ST_TURN : ST_XFER;
                    else         state_d = ST_BUSY;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            ST_TURN: state_d = ST_XFER;
            ST_XFER: if (beat && frame_n) state_d = ST_DONE;
            ST_BUSY: if (frame_n && irdy_n) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            frame_q <= 1'b0;
            rd_q    <= 1'b0;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            frame_q <= frame_n;
            if (accept && addr_ph) begin
                rd_q  <= dec.rd;
                idx_q <= dec_idx;
            end else if (beat) begin
                idx_q <= (idx_q == IDX_W'(NREGS - 1)) ? '0 : idx_q + 1'b1;
            end
        end
    end

    assign cur_idx  = idx_q;
    assign wr_en    = beat && !rd_q;
    assign devsel_n = !((state_q == ST_TURN) || (state_q == ST_XFER));
    assign trdy_n   = (state_q != ST_XFER);
    assign rsp_oe   = (state_q == ST_TURN) || (state_q == ST_XFER) || (state_q == ST_DONE);
    assign ad_oe    = (state_q == ST_XFER) && rd_q;

    AST_NO_CLAIM_WITHOUT_EDGE: assert property (@(posedge clk) disable iff (rst)
        (accept && !addr_ph) |=> (devsel_n && trdy_n)) else $error("no edge claim"); // R2
    AST_MISS_NO_DEVSEL: assert property (@(posedge clk) disable iff (rst)
        (accept && addr_ph && !dec.hit) |=> devsel_n) else $error("miss claimed"); // R3
    AST_WRITE_FAST_RESPONSE: assert property (@(posedge clk) disable iff (rst)
        (accept && addr_ph && dec.hit && !dec.rd) |=> (!devsel_n && !trdy_n)) else $error("write response"); // R4
    AST_READ_TURNAROUND: assert property (@(posedge clk) disable iff (rst)
        (accept && addr_ph && dec.hit && dec.rd) |=> (!devsel_n && trdy_n && !ad_oe)) else $error("turnaround"); // R5
    AST_WAIT_HOLDS_INDEX: assert property (@(posedge clk) disable iff (rst)
        (!trdy_n && irdy_n) |=> $stable(cur_idx)) else $error("index moved on wait"); // R6
    AST_LAST_PHASE_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (!trdy_n && !irdy_n && frame_n) |=> (devsel_n && trdy_n && rsp_oe && !ad_oe)) else $error("release"); // R7
    AST_RELEASE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (rsp_oe && devsel_n) |=> (!rsp_oe || !devsel_n)) else $error("release length"); // R7
    AST_BUSY_SILENT: assert property (@(posedge clk) disable iff (rst)
        ((state_q == ST_BUSY) && !(frame_n && irdy_n)) |=> (devsel_n && !rsp_oe)) else $error("busy response"); // R8

endmodule

// File: rtl/pci_tgt_seq.sv
module pci_tgt_seq
    import tgtseq_pkg::*;
#(
    parameter int          DATA_W    = 32,
    parameter int          NREGS     = 8,
    parameter int          WIN_LSB   = 11,
    parameter logic [31:0] BASE_ADDR = 32'h8000_0000,
    localparam int IDX_W  = $clog2(NREGS),
    localparam int NBYTES = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_n,
    input  logic              irdy_n,
    input  logic              idsel,
    input  logic [DATA_W-1:0] ad_in,
    input  logic [NBYTES-1:0] cbe_n,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    output logic              devsel_n,
    output logic              trdy_n,
    output logic              rsp_oe
);

    claim_t            dec;
    logic [IDX_W-1:0]  dec_idx;
    logic [IDX_W-1:0]  cur_idx;
    logic              wr_en;
    logic [DATA_W-1:0] rd_data;

    tgtseq_decode #(
        .DATA_W    (DATA_W),
        .WIN_LSB   (WIN_LSB),
        .BASE_ADDR (BASE_ADDR),
        .IDX_W     (IDX_W)
    ) i_decode (
        .ad  (ad_in),
        .cmd (cbe_n[3:0]),
        .sel (idsel),
        .dec (dec),
        .idx (dec_idx)
    );

    tgtseq_fsm #(
        .NREGS (NREGS)
    ) i_fsm (
        .clk      (clk),
        .rst      (rst),
        .frame_n  (frame_n),
        .irdy_n   (irdy_n),
        .dec      (dec),
        .dec_idx  (dec_idx),
        .cur_idx  (cur_idx),
        .wr_en    (wr_en),
        .devsel_n (devsel_n),
        .trdy_n   (trdy_n),
        .rsp_oe   (rsp_oe),
        .ad_oe    (ad_oe)
    );

    tgtseq_regfile #(
        .DATA_W (DATA_W),
        .NREGS  (NREGS)
    ) i_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .idx     (cur_idx),
        .wr_data (ad_in),
        .be_n    (cbe_n),
        .rd_data (rd_data)
    );

    assign ad_out = ad_oe ? rd_data : '0;

    AST_READ_DRIVE_NEEDS_RESPONSE: assert property (@(posedge clk) disable iff (rst)
        ad_oe |-> (!trdy_n && !devsel_n && rsp_oe)) else $error("read drive"); // R5

endmodule

// File: tb/test_pci_tgt_seq.sv
module test_pci_tgt_seq;

    localparam int          NREGS = 8;
    localparam logic [31:0] BASE  = 32'h8000_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frame_n = 1'b1;
    logic        irdy_n = 1'b1;
    logic        idsel = 1'b0;
    logic [31:0] ad_in = '0;
    logic [3:0]  cbe_n = 4'hF;
    logic [31:0] ad_out;
    logic        ad_oe, devsel_n, trdy_n, rsp_oe;

    always #5 clk = ~clk;

    pci_tgt_seq i_pci_tgt_seq (
        .clk(clk), .rst(rst), .frame_n(frame_n), .irdy_n(irdy_n), .idsel(idsel),
        .ad_in(ad_in), .cbe_n(cbe_n), .ad_out(ad_out), .ad_oe(ad_oe),
        .devsel_n(devsel_n), .trdy_n(trdy_n), .rsp_oe(rsp_oe)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    bit live = 0;

    // behavioural reference: 0 idle, 1 turnaround, 2 data, 3 foreign, 4 release
    int          m_st = 0;
    bit          m_prevf = 0;
    bit          m_rd = 0;
    int          m_idx = 0;
    logic [31:0] m_regs [NREGS];
    string       m_tag = "R1";
    bit          m_hit;

    always @(posedge clk) begin
        live = 1;
        if (rst) begin
            m_st = 0; m_prevf = 0; m_rd = 0; m_idx = 0; m_tag = "R1";
            foreach (m_regs[i]) m_regs[i] = '0;
        end else begin
            m_tag = "";
            case (m_st)
                0, 4: begin
                    if (m_prevf && !frame_n) begin
                        m_hit = (ad_in % 4 == 0) &&
                                ((((ad_in >> 11) == (BASE >> 11)) && (cbe_n == 4'h6 || cbe_n == 4'h7)) ||
                                 (idsel && (cbe_n == 4'hA || cbe_n == 4'hB)));
                        if (m_hit) begin
                            m_rd  = (cbe_n == 4'h6 || cbe_n == 4'hA);
                            m_idx = (ad_in >> 2) % NREGS;
                            m_tag = (m_st == 4) ? "R9" : (m_rd ? "R5" : "R4");
                            m_st  = m_rd ? 1 : 2;
                        end else begin
                            m_st = 3; m_tag = "R3";
                        end
                    end else begin
                        m_st = 0;
                    end
                end
                1: m_st = 2;
                2: if (!irdy_n) begin
                    if (!m_rd)
                        for (int b = 0; b < 4; b++)
                            if (!cbe_n[b]) m_regs[m_idx][b*8 +: 8] = ad_in[b*8 +: 8];
                    m_idx = (m_idx + 1) % NREGS;
                    if (frame_n) m_st = 4;
                end
                3: if (frame_n && irdy_n) m_st = 0;
                default: m_st = 0;
            endcase
            if (m_tag == "") begin
                case (m_st)
                    0: m_tag = "R2";
                    1: m_tag = "R5";
                    2: m_tag = m_rd ? "R6" : "R4";
                    3: m_tag = "R8";
                    default: m_tag = "R7";
                endcase
            end
            m_prevf = frame_n;
        end
    end

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (live && !finished) begin
            chk(m_tag, "devsel_n", 32'(devsel_n), 32'(!(m_st == 1 || m_st == 2)));
            chk(m_tag, "trdy_n",   32'(trdy_n),   32'(m_st != 2));
            chk(m_tag, "rsp_oe",   32'(rsp_oe),   32'(m_st == 1 || m_st == 2 || m_st == 4));
            chk(m_tag, "ad_oe",    32'(ad_oe),    32'(m_st == 2 && m_rd));
            if (m_st == 2 && m_rd) chk("R6", "ad_out", ad_out, m_regs[m_idx]);
        end
    end

    task automatic step();
        @(negedge clk);
        #2;
    endtask

    task automatic idle(input int n);
        frame_n = 1; irdy_n = 1; idsel = 0; cbe_n = 4'hF; ad_in = '0;
        repeat (n) step();
    endtask

    task automatic txn(input logic [31:0] addr, input logic [3:0] cmd, input logic sel, input int n,
                       input logic [31:0] wdat, input logic [3:0] be, input logic [7:0] waits, input bit spoof);
        int  k = 0;
        int  cyc = 0;
        bit  rd = (cmd == 4'h6 || cmd == 4'hA || cmd == 4'h2);
        frame_n = 0; irdy_n = 1; ad_in = addr; cbe_n = cmd; idsel = sel;
        step();
        while (k < n && cyc < n + 8) begin
            logic w = waits[cyc % 8];
            logic t;
            irdy_n  = w;
            frame_n = (k == n - 1 && !w) ? 1'b1 : 1'b0;
            ad_in   = rd ? 32'h0 : wdat + 32'(k) * 32'h0101_0101;
            cbe_n   = rd ? 4'h0 : be;
            idsel   = 0;
            if (spoof) begin
                ad_in = 32'h0000_0004; cbe_n = 4'hB; idsel = 1;
            end
            t = trdy_n;
            step();
            if (!w && !t) k++;
            cyc++;
        end
        if (k < n) begin
            frame_n = 1; irdy_n = 0; idsel = 0;
            step();
            irdy_n = 1;
            step();
        end
    endtask

    initial begin
        #200000;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            finished = 1;
            $finish;
        end
    end

    initial begin
        // R1: reset, with a configuration write pattern already on the bus (R2)
        rst = 1;
        repeat (2) step();
        frame_n = 0; ad_in = 32'h4; cbe_n = 4'hB; idsel = 1;
        step();
        rst = 0;
        repeat (4) step();                                         // R2: low level, no edge
        idle(2);
        txn(32'h0000_0004, 4'hB, 1, 1, 32'h1122_3344, 4'h0, 8'h00, 0);   // R4 config write idx 1
        idle(1);
        txn(BASE + 32'h18, 4'h7, 0, 4, 32'hA0B0_C0D0, 4'h0, 8'b0000_0100, 0); // R6 wrap 6,7,0,1
        idle(1);
        txn(BASE + 32'h8, 4'h7, 0, 1, 32'hAABB_CCDD, 4'b1010, 8'h00, 0); // R4 byte enables
        idle(1);
        txn(BASE + 32'h18, 4'h6, 0, 5, 32'h0, 4'h0, 8'b0001_0010, 0);  // R5 R6 read burst
        idle(1);
        txn(32'h0000_0008, 4'hA, 0, 3, 32'h0, 4'h0, 8'h00, 1);         // R3 R8 no idsel, spoofed
        idle(1);
        txn(BASE + 32'h800, 4'h6, 0, 1, 32'h0, 4'h0, 8'h00, 0);        // R3 outside window
        idle(1);
        txn(BASE + 32'h1, 4'h7, 0, 1, 32'hDEAD_BEEF, 4'h0, 8'h00, 0);  // R3 low bits not 00
        idle(1);
        txn(BASE, 4'h2, 0, 1, 32'h0, 4'h0, 8'h00, 0);                  // R3 other command
        idle(1);
        txn(BASE + 32'h10, 4'h7, 0, 2, 32'h5555_AAAA, 4'h0, 8'h00, 0); // R4 write idx 4,5
        txn(32'h0000_0010, 4'hA, 1, 2, 32'h0, 4'h0, 8'h00, 0);         // R9 back-to-back read
        idle(1);
        txn(BASE + 32'h4, 4'h6, 0, 2, 32'h0, 4'h0, 8'h00, 0);          // R5 read idx 1,2
        idle(3);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule